// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the digital divider section of a frequency synthesizer. It works in one clock domain. Edges of the oscillator and of the reference arrive as one-cycle enable strobes, `osc_tick` and `ref_tick`. The oscillator chain has three parts: a prescaler that divides by P or P+1, a main counter N, and a swallow counter A. The swallow counter holds the prescaler at P+1 from the start of each output period until it has counted A prescaler cycles. The prescaler then divides by P until the period ends. One feedback period therefore spans N·P+A oscillator ticks. Setting A to zero turns the chain into a plain divide by N·P.

A separate counter divides the reference strobe by R. Each chain emits a one-cycle comparison pulse at the end of its period, for a phase detector that lives outside this block. When the loop is locked, the oscillator runs at f_ref·(N·P+A)/R.

Software programs N, A, R and the modulus pair through a small write port. Each value is checked when it is written and held in a staging register. A chain copies its staged values into its working set only when its current period ends, so a write never cuts a period short. A write that breaks a rule is refused and raises an error flag.

Top module: `pulse_swallow_div`

## Requirements
- R1: After reset, `fb_pulse`, `ref_pulse` and `cfg_err` are low, and the settings are N=4, A=1, R=3 with the low modulus pair (P=32).
- R2: With settings N, A and P, consecutive `fb_pulse` pulses are N·P+A `osc_tick` strobes apart, and each pulse lasts exactly one clock.
- R3: With A=0, the feedback period is N·P strobes.
- R4: Writing 0 to the modulus address selects P=32 (divide by 32/33). Writing 1 selects P=64 (divide by 64/65).
- R5: Consecutive `ref_pulse` pulses are R `ref_tick` strobes apart. With R=1, every reference strobe produces a pulse.
- R6: A new setting takes effect only at the end of the period that is running in the affected chain. The period during which the write happens keeps its old length.
- R7: A write is refused in any of these cases: A ≥ N (checked against the staged N), N < 2, R = 0, a modulus value above 1, or a value with bits set above the field width (N is 11 bits, A is 7 bits, R is 12 bits). On a refused write, `cfg_err` goes high on the next clock and the settings stay unchanged. The next accepted write clears `cfg_err`.
- R8: Clock cycles without a strobe do not advance a chain. Period lengths count strobes, not clock cycles.
- R9: The write addresses are 0 for N, 1 for A, 2 for R and 3 for the modulus select. A write takes effect on the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_tick | input | 1 | One strobe per oscillator edge |
| ref_tick | input | 1 | One strobe per reference edge |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 2 | Write address: 0 N, 1 A, 2 R, 3 modulus |
| cfg_wdata | input | 16 | Write value |
| fb_pulse | output | 1 | One-clock pulse at the end of each feedback period |
| ref_pulse | output | 1 | One-clock pulse at the end of each reference period |
| cfg_err | output | 1 | High after a refused write, until the next accepted write |

## Verification
The assertions assume that every working setting obeys A < N and N ≥ 2. With P at least 32, this means a feedback period always has at least 64 strobes, so two feedback pulses can never land on adjacent clocks. The assertions also assume that counters are reset only when a period ends. The bench issues its writes in the clock just after a pulse, far from the next period end, so the old period and the new period can each be measured in full. Every value the bench writes keeps A below the staged N, except for the writes that are meant to be refused.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    ADDR_N    = 2'd0,
    ADDR_A    = 2'd1,
    ADDR_R    = 2'd2,
    ADDR_MODE = 2'd3
  } cfg_addr_e;

  localparam int unsigned MIN_N = 2;
endpackage

// File: rtl/psd_cfg.sv
module psd_cfg
  import psd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int N_W      = 11,
  parameter int A_W      = 7,
  parameter int R_W      = 12,
  parameter int N_RST    = 4,
  parameter int A_RST    = 1,
  parameter int R_RST    = 3,
  parameter bit MODE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              osc_end,
  input  logic              ref_end,
  output logic [N_W-1:0]    n_act,
  output logic [A_W-1:0]    a_act,
  output logic              mode_act,
  output logic [R_W-1:0]    r_act,
  output logic              cfg_err
);
  logic [N_W-1:0] n_stg, n_stg_d, n_act_d;
  logic [A_W-1:0] a_stg, a_stg_d, a_act_d;
  logic [R_W-1:0] r_stg, r_stg_d, r_act_d;
  logic           mode_stg, mode_stg_d, mode_act_d;
  logic           err_d, accept;
  logic           fits_n, fits_a, fits_r;

  assign fits_n = (cfg_wdata >> N_W) == '0;
  assign fits_a = (cfg_wdata >> A_W) == '0;
  assign fits_r = (cfg_wdata >> R_W) == '0;

  // staging: validate and capture writes
  always_comb begin
    accept     = 1'b0;
    n_stg_d    = n_stg;
    a_stg_d    = a_stg;
    r_stg_d    = r_stg;
    mode_stg_d = mode_stg;
    err_d      = cfg_err;
    if (cfg_we) begin
      case (cfg_addr)
        ADDR_N:    accept = fits_n && (cfg_wdata >= DATA_W'(MIN_N))
                            && (DATA_W'(a_stg) < cfg_wdata);
        ADDR_A:    accept = fits_a && (cfg_wdata < DATA_W'(n_stg));
        ADDR_R:    accept = fits_r && (cfg_wdata != '0);
        ADDR_MODE: accept = (cfg_wdata <= DATA_W'(1));
        default:   accept = 1'b0;
      endcase
      err_d = !accept;
      if (accept) begin
        case (cfg_addr)
          ADDR_N:    n_stg_d    = cfg_wdata[N_W-1:0];
          ADDR_A:    a_stg_d    = cfg_wdata[A_W-1:0];
          ADDR_R:    r_stg_d    = cfg_wdata[R_W-1:0];
          default:   mode_stg_d = cfg_wdata[0];
        endcase
      end
    end
  end

  // working sets: copied only at a period boundary
  always_comb begin
    n_act_d    = n_act;
    a_act_d    = a_act;
    mode_act_d = mode_act;
    r_act_d    = r_act;
    if (osc_end) begin
      n_act_d    = n_stg;
      a_act_d    = a_stg;
      mode_act_d = mode_stg;
    end
    if (ref_end) begin
      r_act_d = r_stg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_stg    <= N_W'(N_RST);
      a_stg    <= A_W'(A_RST);
      r_stg    <= R_W'(R_RST);
      mode_stg <= MODE_RST;
      n_act    <= N_W'(N_RST);
      a_act    <= A_W'(A_RST);
      r_act    <= R_W'(R_RST);
      mode_act <= MODE_RST;
      cfg_err  <= 1'b0;
    end else begin
      n_stg    <= n_stg_d;
      a_stg    <= a_stg_d;
      r_stg    <= r_stg_d;
      mode_stg <= mode_stg_d;
      n_act    <= n_act_d;
      a_act    <= a_act_d;
      r_act    <= r_act_d;
      mode_act <= mode_act_d;
      cfg_err  <= err_d;
    end
  end

  // R7: working oscillator settings always legal
  p_active_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (N_W'(a_act) < n_act) && (n_act >= N_W'(MIN_N)) && (r_act != '0));

  // R7: refused write leaves staging untouched and raises the flag
  p_hold_on_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !accept) |=> ($stable(n_stg) && $stable(a_stg) && $stable(r_stg)
                             && $stable(mode_stg) && cfg_err));

  // R6: oscillator working set moves only at a feedback boundary
  p_osc_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_end |=> ($stable(n_act) && $stable(a_act) && $stable(mode_act)));

  // R6: reference working set moves only at a reference boundary
  p_ref_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_end |=> $stable(r_act));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P_LO = 32,
  parameter int P_HI = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mode_hi,
  input  logic plus1,
  output logic wrap
);
  localparam int C_W = $clog2(P_HI + 2);

  logic [C_W-1:0] cnt, cnt_d, last;

  assign last = (mode_hi ? C_W'(P_HI - 1) : C_W'(P_LO - 1)) + C_W'(plus1);
  assign wrap = tick && (cnt == last);

  always_comb begin
    cnt_d = cnt;
    if (tick) begin
      cnt_d = wrap ? '0 : cnt + C_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R8: no strobe, no movement
  p_pre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R2: prescaler never passes the largest modulus
  p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= C_W'(P_HI));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
  parameter int N_W = 11,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_wrap,
  input  logic [N_W-1:0] n_act,
  input  logic [A_W-1:0] a_act,
  output logic           plus1,
  output logic           period_end
);
  logic [N_W-1:0] n_cnt, n_cnt_d;
  logic [A_W-1:0] a_cnt, a_cnt_d;

  assign plus1      = (a_cnt != a_act);
  assign period_end = pre_wrap && (n_cnt == (n_act - N_W'(1)));

  always_comb begin
    n_cnt_d = n_cnt;
    a_cnt_d = a_cnt;
    if (period_end) begin
      n_cnt_d = '0;
      a_cnt_d = '0;
    end else if (pre_wrap) begin
      n_cnt_d = n_cnt + N_W'(1);
      if (plus1) a_cnt_d = a_cnt + A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt <= '0;
      a_cnt <= '0;
    end else begin
      n_cnt <= n_cnt_d;
      a_cnt <= a_cnt_d;
    end
  end

  // R2: counters stay within the programmed window
  p_swallow_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cnt <= a_act) && (n_cnt < n_act));

  // R2: every period with A > 0 starts on the P+1 modulus
  p_start_plus1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_cnt == '0) && (a_act != '0)) |-> plus1);

  // R3: with A = 0 the modulus never leaves P
  p_single_modulus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_act == '0) |-> !plus1);
endmodule

// File: rtl/psd_refdiv.sv
module psd_refdiv #(
  parameter int R_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [R_W-1:0] r_act,
  output logic           period_end
);
  logic [R_W-1:0] r_cnt, r_cnt_d;

  assign period_end = tick && (r_cnt == (r_act - R_W'(1)));

  always_comb begin
    r_cnt_d = r_cnt;
    if (tick) r_cnt_d = period_end ? '0 : r_cnt + R_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_cnt <= '0;
    else        r_cnt <= r_cnt_d;
  end

  // R5: reference count stays below R
  p_rcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt < r_act);

  // R8: no strobe, no movement
  p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(r_cnt));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int DATA_W   = 16,
  parameter int N_W      = 11,
  parameter int A_W      = 7,
  parameter int R_W      = 12,
  parameter int P_LO     = 32,
  parameter int P_HI     = 64,
  parameter int N_RST    = 4,
  parameter int A_RST    = 1,
  parameter int R_RST    = 3,
  parameter bit MODE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              ref_tick,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              fb_pulse,
  output logic              ref_pulse,
  output logic              cfg_err
);
  logic [N_W-1:0] n_act;
  logic [A_W-1:0] a_act;
  logic [R_W-1:0] r_act;
  logic           mode_act;
  logic           pre_wrap, plus1, osc_end, ref_end;
  logic           fb_d, ref_d;

  psd_cfg #(
    .DATA_W(DATA_W), .N_W(N_W), .A_W(A_W), .R_W(R_W),
    .N_RST(N_RST), .A_RST(A_RST), .R_RST(R_RST), .MODE_RST(MODE_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .osc_end(osc_end), .ref_end(ref_end),
    .n_act(n_act), .a_act(a_act), .mode_act(mode_act), .r_act(r_act),
    .cfg_err(cfg_err)
  );

  psd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .mode_hi(mode_act),
    .plus1(plus1), .wrap(pre_wrap)
  );

  psd_swallow #(.N_W(N_W), .A_W(A_W)) u_swl (
    .clk(clk), .rst_n(rst_n), .pre_wrap(pre_wrap), .n_act(n_act),
    .a_act(a_act), .plus1(plus1), .period_end(osc_end)
  );

  psd_refdiv #(.R_W(R_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .r_act(r_act),
    .period_end(ref_end)
  );

  always_comb begin
    fb_d  = osc_end;
    ref_d = ref_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      fb_pulse  <= fb_d;
      ref_pulse <= ref_d;
    end
  end

  // R2: feedback pulse lasts one clock (period is at least 64 strobes)
  p_fb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R8: feedback pulse needs an oscillator strobe the clock before
  p_fb_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> !fb_pulse);
endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc_tick, ref_tick, cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        fb_pulse, ref_pulse, cfg_err;
  int          n_chk = 0;
  int          n_fail = 0;

  pulse_swallow_div dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ref_tick(ref_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Count strobes between two consecutive pulses of the chosen chain.
  // Optionally issue one write in the clock after the first pulse.
  task automatic measure(input bit use_ref, input int gap, input bit do_wr,
                         input logic [1:0] wa, input logic [15:0] wd,
                         output int ticks);
    bit started = 1'b0;
    bit pend = 1'b0;
    int cnt = 0;
    int cyc = 0;
    ticks = -1;
    for (int it = 0; it < 5000; it++) begin
      bit pul, tk, nxt;
      @(posedge clk); #1;
      if (pend) begin cfg_we = 1'b0; pend = 1'b0; end
      pul = use_ref ? ref_pulse : fb_pulse;
      tk  = use_ref ? ref_tick  : osc_tick;
      if (pul) begin
        if (started) begin ticks = cnt; break; end
        started = 1'b1; cnt = 0;
        if (do_wr) begin
          cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; pend = 1'b1;
        end
      end
      if (started && tk) cnt++;
      cyc++;
      nxt = (gap == 0) || (cyc % gap != 0);
      osc_tick = use_ref ? 1'b0 : nxt;
      ref_tick = use_ref ? nxt : 1'b0;
    end
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; osc_tick = 1'b0; ref_tick = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(fb_pulse == 1'b0, "R1 fb_pulse", int'(fb_pulse), 0);
    chk(ref_pulse == 1'b0, "R1 ref_pulse", int'(ref_pulse), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_default();
    int t;
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 4 * 32 + 1, "R1 R2 default ratio", t, 129);
  endtask

  task automatic t_program();
    int t;
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd3);
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 163, "R2 R9 N=5 A=3 P=32", t, 163);
    chk(cfg_err == 1'b0, "R9 accepted writes", int'(cfg_err), 0);
  endtask

  task automatic t_modulus();
    int t;
    wr(2'd3, 16'd1);
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 323, "R4 P=64 ratio", t, 323);
  endtask

  task automatic t_single();
    int t;
    wr(2'd1, 16'd0);
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 320, "R3 A=0 ratio", t, 320);
  endtask

  task automatic t_gapped();
    int t;
    measure(1'b0, 3, 1'b0, 2'd0, 16'd0, t);
    chk(t == 320, "R8 gapped strobes", t, 320);
  endtask

  task automatic t_reject();
    int t;
    wr(2'd1, 16'd5);
    chk(cfg_err == 1'b1, "R7 A>=N refused", int'(cfg_err), 1);
    wr(2'd0, 16'd1);
    chk(cfg_err == 1'b1, "R7 N<2 refused", int'(cfg_err), 1);
    wr(2'd0, 16'h0800);
    chk(cfg_err == 1'b1, "R7 N over width refused", int'(cfg_err), 1);
    wr(2'd2, 16'd0);
    chk(cfg_err == 1'b1, "R7 R=0 refused", int'(cfg_err), 1);
    wr(2'd3, 16'd2);
    chk(cfg_err == 1'b1, "R7 modulus>1 refused", int'(cfg_err), 1);
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 320, "R7 settings unchanged", t, 320);
    wr(2'd1, 16'd2);
    chk(cfg_err == 1'b0, "R7 flag cleared", int'(cfg_err), 0);
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 322, "R7 accepted A=2", t, 322);
  endtask

  task automatic t_boundary();
    int t;
    measure(1'b0, 0, 1'b1, 2'd0, 16'd3, t);
    chk(t == 322, "R6 period in progress kept", t, 322);
    measure(1'b0, 0, 1'b0, 2'd0, 16'd0, t);
    chk(t == 194, "R6 new N applied", t, 194);
  endtask

  task automatic t_ref();
    int t;
    measure(1'b1, 2, 1'b0, 2'd0, 16'd0, t);
    chk(t == 3, "R5 default R", t, 3);
    measure(1'b1, 2, 1'b1, 2'd2, 16'd7, t);
    chk(t == 3, "R6 ref period in progress kept", t, 3);
    measure(1'b1, 2, 1'b0, 2'd0, 16'd0, t);
    chk(t == 7, "R5 R=7", t, 7);
    wr(2'd2, 16'd1);
    measure(1'b1, 2, 1'b0, 2'd0, 16'd0, t);
    measure(1'b1, 2, 1'b0, 2'd0, 16'd0, t);
    chk(t == 1, "R5 R=1", t, 1);
  endtask

  initial begin
    t_reset();
    t_default();
    t_program();
    t_modulus();
    t_single();
    t_gapped();
    t_reject();
    t_boundary();
    t_ref();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule